// File: doc/BRIEF.md
# Serial-Load DAC Code Register

This block is the digital front end of a 12-bit voltage DAC that is loaded over a three-wire serial link. A serial bit stream is shifted into a 12-bit shift register on rising edges of a serial clock, but only while an active-low select is held. A separate active-low load strobe makes the DAC code register follow the shift register for as long as the strobe is low. The code register keeps the last value when the strobe returns high.

An active-low clear input forces the code register to zero at once, with no clock needed. The clear leaves the shift register untouched. All serial inputs are sampled by a faster system clock through a synchronizer. The transparent behaviour is modelled as an update on every system cycle in which the sampled strobe is low.

Next to the code, the block gives the ideal output level in microvolts, at 500 µV per step. It also has a sticky flag that catches serial shifting while the strobe is low. Only the clear input or the system reset lowers that flag.

Top module: `sdac_front`

## Requirements
- R1: After system reset, the code output is 0, the microvolt output is 0 and the protocol flag is 0.
- R2: Twelve rising serial-clock edges with select low shift in a word MSB first. A later strobe pulse makes the code equal that word.
- R3: Rising serial-clock edges with select high leave the shift register unchanged. A following strobe pulse shows the earlier contents.
- R4: While the strobe is low and clear is high, the code follows the shift register, including bits shifted in during that time.
- R5: After the strobe returns high, new shifting does not change the code.
- R6: Driving clear low makes the code 0 with no system clock edge. The code stays 0 after clear returns high while the strobe is high.
- R7: Clear does not alter the shift register. A strobe pulse after a clear restores the word shifted in before it.
- R8: A shifting serial edge that arrives while the strobe is low sets the protocol flag. The flag then stays set until clear is driven low, and shifting with the strobe high never sets it.
- R9: The microvolt output equals the code times 500, so code 4095 gives 2047500 and code 0 gives 0.
- R10: Clear low overrides a low strobe and holds the code at 0. When clear is released with the strobe still low, the code takes the shift register value again.
- R11: Shifting more than 12 bits keeps only the last 12 bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data, MSB first |
| sel_n | input | 1 | Active-low select, which enables shifting |
| strobe_n | input | 1 | Active-low load strobe, transparent while low |
| zero_n | input | 1 | Active-low asynchronous clear of the code register |
| dac_code | output | 12 | DAC code register |
| out_uv | output | 22 | Ideal output level in microvolts |
| proto_err | output | 1 | Sticky flag for shifting while the strobe is low |

## Verification
The bench builds the block with its default parameters: a 12-bit code, 500 µV per step, a 22-bit microvolt output and a two-stage synchronizer. This width lets the vector table reach the full-scale code 4095 and its level of 2047500 µV. The 16-bit overshift test then shows the four oldest bits being dropped. The two-stage synchronizer gives each serial level a fixed latency in system clocks, and the bench holds every serial level well beyond that latency. The clear checks sample one nanosecond after the clear edge, with no system clock edge in between.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned DEF_CODE_W     = 12;
  localparam int unsigned DEF_UV_PER_LSB = 500;

  // ideal output level of one code, in microvolts
  function automatic int unsigned code_to_uv(input int unsigned code,
                                             input int unsigned per_lsb);
    return code * per_lsb;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= INIT;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              sel_n_s,
  output logic              shift_evt,
  output logic [CODE_W-1:0] shreg
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  // rising serial edge, counted only with select asserted
  assign shift_evt = sclk_s & ~sclk_q & ~sel_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (shift_evt) shreg <= {shreg[CODE_W-2:0], din_s};
  end
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_n,
  input  logic              load_en,
  input  logic              shift_evt,
  input  logic [CODE_W-1:0] shreg,
  output logic [CODE_W-1:0] hold,
  output logic              err
);
  always_ff @(posedge clk or negedge rst_n or negedge zero_n) begin
    if (!rst_n)       hold <= '0;
    else if (!zero_n) hold <= '0;
    else if (load_en) hold <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n or negedge zero_n) begin
    if (!rst_n)                     err <= 1'b0;
    else if (!zero_n)               err <= 1'b0;
    else if (shift_evt && load_en)  err <= 1'b1;
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned UV_PER_LSB  = DEF_UV_PER_LSB,
  parameter int unsigned UV_W        = 22,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              sel_n,
  input  logic              strobe_n,
  input  logic              zero_n,
  output logic [CODE_W-1:0] dac_code,
  output logic [UV_W-1:0]   out_uv,
  output logic              proto_err
);
  localparam int unsigned NSYNC = 4;
  // idle levels: strobe high, select high, data low, serial clock low
  localparam logic [NSYNC-1:0] SYNC_INIT = 4'b1100;

  logic [NSYNC-1:0]  raw_in, sync_q;
  logic              sclk_s, din_s, sel_n_s, strobe_n_s;
  logic              shift_evt;
  logic              load_en;
  logic [CODE_W-1:0] shreg;

  assign raw_in = {strobe_n, sel_n, ser_din, ser_clk};

  sdac_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
  );

  assign sclk_s     = sync_q[0];
  assign din_s      = sync_q[1];
  assign sel_n_s    = sync_q[2];
  assign strobe_n_s = sync_q[3];
  assign load_en    = ~strobe_n_s;

  sdac_shift #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .din_s(din_s),
    .sel_n_s(sel_n_s), .shift_evt(shift_evt), .shreg(shreg)
  );

  sdac_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .zero_n(zero_n), .load_en(load_en),
    .shift_evt(shift_evt), .shreg(shreg), .hold(dac_code), .err(proto_err)
  );

  assign out_uv = UV_W'(code_to_uv(32'(dac_code), UV_PER_LSB));
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int unsigned CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              zero_n,
  input logic              shift_evt,
  input logic              load_en,
  input logic [CODE_W-1:0] shreg,
  input logic [CODE_W-1:0] hold,
  input logic              err
);
  assert_shift_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(shreg));

  assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
    load_en |=> hold == $past(shreg));

  assert_latched_R5: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
    !load_en |=> $stable(hold));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |-> hold == '0);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
    (shift_evt && load_en) |=> err);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || !zero_n)
    err |=> err);

  assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |-> !err);
endmodule

bind sdac_front sdac_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .zero_n(zero_n), .shift_evt(shift_evt),
  .load_en(load_en), .shreg(shreg), .hold(dac_code), .err(proto_err)
);

// File: tb/sdac_front_bench.sv
`timescale 1ns/1ps
module sdac_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_din = 1'b0, sel_n = 1'b1;
  logic        strobe_n = 1'b1, zero_n = 1'b1;
  logic [11:0] dac_code;
  logic [21:0] out_uv;
  logic        proto_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdac_front u_sdac_front (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .sel_n(sel_n), .strobe_n(strobe_n), .zero_n(zero_n),
    .dac_code(dac_code), .out_uv(out_uv), .proto_err(proto_err)
  );

  localparam int NV = 6;
  localparam logic [11:0] VEC_CODE [NV] = '{12'hABC, 12'h001, 12'h800, 12'hFFF, 12'h555, 12'h3A7};
  localparam int unsigned VEC_UV   [NV] = '{1374000, 500, 1024000, 2047500, 682500, 467500};

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift n bits of w, MSB first, with the given select level
  task automatic shift_word(input logic [15:0] w, input int n, input logic sel);
    sel_n = sel;
    idle(3);
    for (int i = n-1; i >= 0; i--) begin
      ser_din = w[i];
      idle(3);
      ser_clk = 1'b1;
      idle(3);
      ser_clk = 1'b0;
    end
    idle(3);
    sel_n = 1'b1;
    idle(3);
  endtask

  task automatic pulse_strobe();
    strobe_n = 1'b0;
    idle(5);
    strobe_n = 1'b1;
    idle(5);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk("R1 code", dac_code, 0);
    chk("R1 uv", out_uv, 0);
    chk("R1 flag", proto_err, 0);

    // R2 / R9 table walk
    for (int k = 0; k < NV; k++) begin
      shift_word({4'h0, VEC_CODE[k]}, 12, 1'b0);
      pulse_strobe();
      chk("R2 code", dac_code, VEC_CODE[k]);
      chk("R9 uv", out_uv, VEC_UV[k]);
    end
    chk("R8 no flag with strobe high", proto_err, 0);

    // R5: shifting after latch leaves code alone
    shift_word(16'h0123, 12, 1'b0);
    chk("R5 latched", dac_code, 12'h3A7);
    pulse_strobe();
    chk("R2 second load", dac_code, 12'h123);

    // R3: select high ignores serial clock
    shift_word(16'h0FFF, 12, 1'b1);
    pulse_strobe();
    chk("R3 select high", dac_code, 12'h123);

    // R11: overshift keeps last 12 bits
    shift_word(16'hBEEF, 16, 1'b0);
    pulse_strobe();
    chk("R11 overshift", dac_code, 12'hEEF);

    // R6: asynchronous clear
    zero_n = 1'b0;
    #1;
    chk("R6 async zero", dac_code, 0);
    chk("R9 zero uv", out_uv, 0);
    idle(3);
    zero_n = 1'b1;
    idle(4);
    chk("R6 stays zero", dac_code, 0);

    // R7: shift register untouched by clear
    pulse_strobe();
    chk("R7 shreg kept", dac_code, 12'hEEF);

    // R10: clear overrides low strobe
    zero_n = 1'b0;
    idle(2);
    strobe_n = 1'b0;
    idle(5);
    chk("R10 override", dac_code, 0);
    zero_n = 1'b1;
    idle(4);
    chk("R10 release follows", dac_code, 12'hEEF);

    // R4 / R8: shifting with strobe low
    shift_word(16'h05A5, 12, 1'b0);
    chk("R4 follows shift", dac_code, 12'h5A5);
    chk("R8 flag set", proto_err, 1);
    strobe_n = 1'b1;
    idle(5);
    shift_word(16'h0111, 12, 1'b0);
    chk("R8 flag sticky", proto_err, 1);
    chk("R5 held after strobe", dac_code, 12'h5A5);
    zero_n = 1'b0;
    #1;
    chk("R8 clear drops flag", proto_err, 0);
    idle(3);
    zero_n = 1'b1;
    idle(3);
    chk("R8 flag stays low", proto_err, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule